// File: doc/BRIEF.md
# Multiplier-Based Left Shifter

This block shifts an 18-bit operand left by 0 to 16 places without a multiplexer tree. The shift amount is decoded into a one-hot power-of-two operand, and a signed 18x18 multiplier forms the product of that operand and the data. The 36-bit product is the shifted value. The multiplier's two's-complement arithmetic fills the vacated low bits with zeros. It also fills the bits above the shifted data with copies of the data operand's top bit.

A mode input chooses between two shifts. A logical shift moves the lower 17 data bits, with the top data bit forced low, so the high bits fill with zeros. An arithmetic shift treats all 18 bits as a signed value, so the sign is carried up through the high bits. An amount above 16 cannot be encoded in a positive 18-bit signed operand. Such an amount raises an error flag and gives a zero result. Each strobed request is registered and appears one cycle later with its own valid pulse.

Top module: `mul_shifter`

## Requirements
- R1: While reset is active (rst_n low) and in the first cycle after it, out_valid, out_err and every bit of out_result are 0.
- R2: out_valid is 1 in exactly the cycle after a clock edge that sampled in_valid high, and 0 after an edge that sampled it low.
- R3: With in_arith = 0 and in_shamt = n ≤ 16, out_result equals the zero-extended value of in_data[16:0] times 2^n. in_data[17] has no effect, and out_result[35:33] are 0.
- R4: With in_arith = 1 and in_shamt = n ≤ 16, out_result equals the 36-bit two's-complement value of the signed in_data times 2^n. out_result[35] then equals in_data[17].
- R5: For a legal shift n, out_result[n-1:0] are all 0.
- R6: An in_shamt from 17 to 31 gives out_err = 1 and out_result = 0 in both modes, whatever the data.
- R7: A clock edge with in_valid low leaves out_result and out_err unchanged.
- R8: An in_shamt from 0 to 16 gives out_err = 0, and the internal power-of-two operand then has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_data | input | 18 | Data operand |
| in_shamt | input | 5 | Left shift amount; 0 to 16 are legal |
| in_arith | input | 1 | 1 = arithmetic shift, 0 = logical shift |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_result | output | 36 | Registered shifted value |
| out_err | output | 1 | Shift amount was out of range |

## Verification
Range checking and sign fill can both apply to one request. This happens with an arithmetic request on negative data whose amount is 17 or more. Here the error path must win, so the result is zero rather than all ones. The bench provokes this case by sending the most negative value and the all-ones pattern in arithmetic mode at every illegal amount. It sends these back to back with legal requests, so a stale sign fill or a stale error flag shows up in the next cycle. A behavioural reference built on integer shifts judges every clock.

// File: rtl/mulshift_pkg.sv
package mulshift_pkg;
  localparam int DATA_W    = 18;
  localparam int PROD_W    = 2 * DATA_W;
  localparam int MAX_SHIFT = DATA_W - 2;
  localparam int SHAMT_W   = $clog2(DATA_W + 14);

  // Data operand as presented to the multiplier: logical mode clears the sign bit.
  function automatic logic [DATA_W-1:0] condition_data(input logic [DATA_W-1:0] d,
                                                       input logic arith);
    return arith ? d : {1'b0, d[DATA_W-2:0]};
  endfunction

  // True when the amount cannot be encoded as a positive power of two.
  function automatic logic shamt_illegal(input logic [SHAMT_W-1:0] s);
    return int'(s) > MAX_SHIFT;
  endfunction

  // Mask of the bits strictly below a shift amount.
  function automatic logic [PROD_W-1:0] low_mask(input logic [SHAMT_W-1:0] s);
    logic [PROD_W-1:0] m;
    m = '0;
    for (int i = 0; i < PROD_W; i++) m[i] = (i < int'(s));
    return m;
  endfunction
endpackage

// File: rtl/shamt_decoder.sv
module shamt_decoder
  import mulshift_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int S_W = SHAMT_W,
  parameter int MAX = MAX_SHIFT
) (
  input  logic [S_W-1:0] shamt,
  output logic [W-1:0]   pow_op,
  output logic           dec_err
);
  assign dec_err = int'(shamt) > MAX;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i <= MAX) begin : g_legal
      assign pow_op[i] = !dec_err && (shamt == S_W'(i));
    end else begin : g_sign
      assign pow_op[i] = 1'b0;
    end
  end

  // R8: a legal amount yields a single set bit in the operand
  always_comb begin
    a_pow_onehot_r8: assert (dec_err || $countones(pow_op) == 1)
      else $error("power operand not one-hot for legal amount");
  end
endmodule

// File: rtl/signed_mult.sv
module signed_mult #(
  parameter int A_W = 18,
  parameter int P_W = 2 * A_W
) (
  input  logic signed [A_W-1:0] a,
  input  logic signed [A_W-1:0] b,
  output logic signed [P_W-1:0] p
);
  logic signed [P_W-1:0] a_x;
  logic signed [P_W-1:0] b_x;

  assign a_x = P_W'(a);
  assign b_x = P_W'(b);
  assign p   = a_x * b_x;
endmodule

// File: rtl/mul_shifter.sv
module mul_shifter
  import mulshift_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   in_data,
  input  logic [SHAMT_W-1:0]  in_shamt,
  input  logic                in_arith,
  output logic                out_valid,
  output logic [PROD_W-1:0]   out_result,
  output logic                out_err
);
  logic [DATA_W-1:0] data_op;
  logic [DATA_W-1:0] pow_op;
  logic              dec_err;
  logic [PROD_W-1:0] product;

  assign data_op = condition_data(in_data, in_arith);

  shamt_decoder #(.W(DATA_W), .S_W(SHAMT_W), .MAX(MAX_SHIFT)) u_dec (
    .shamt  (in_shamt),
    .pow_op (pow_op),
    .dec_err(dec_err)
  );

  signed_mult #(.A_W(DATA_W), .P_W(PROD_W)) u_mul (
    .a(data_op),
    .b(pow_op),
    .p(product)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_err    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= product;
        out_err    <= dec_err;
      end
    end
  end

  // R2: one-cycle latency for the strobe
  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3: logical shift never reaches the top three product bits
  p_logic_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_arith && !shamt_illegal(in_shamt)) |=> (out_result[PROD_W-1 -: 3] == 3'b000));
  // R4: arithmetic shift carries the data sign to the top bit
  p_arith_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_arith && !shamt_illegal(in_shamt)) |=> (out_result[PROD_W-1] == $past(in_data[DATA_W-1])));
  // R5: vacated low bits are zero
  p_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !shamt_illegal(in_shamt)) |=> ((out_result & low_mask($past(in_shamt))) == '0));
  // R6: out-of-range amount flags and zeroes the result
  p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_result == '0));
  p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shamt_illegal(in_shamt)) |=> out_err);
  // R7: idle cycles hold the output
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_err)));
endmodule

// File: tb/mul_shifter_tb.sv
module mul_shifter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [17:0] in_data = '0;
  logic [4:0]  in_shamt = '0;
  logic        in_arith = 1'b0;
  logic        out_valid;
  logic [35:0] out_result;
  logic        out_err;

  int n_checks = 0;
  int n_fail   = 0;

  // reference state after the next edge
  logic        exp_valid = 1'b0;
  logic [35:0] exp_res = '0;
  logic        exp_err = 1'b0;

  always #5 clk = ~clk;

  mul_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_shamt(in_shamt), .in_arith(in_arith), .out_valid(out_valid),
    .out_result(out_result), .out_err(out_err)
  );

  function automatic logic [35:0] ref_shift(input logic [17:0] d, input int n, input logic ar);
    longint v;
    if (n > 16) return 36'd0;
    if (ar) v = longint'($signed(d));
    else    v = longint'(d & 18'h1FFFF);
    v = v * (longint'(1) << n);
    return v[35:0];
  endfunction

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check({tag, " R2 valid"}, 36'(out_valid), 36'(exp_valid));
    check({tag, " R6 err"},   36'(out_err),   36'(exp_err));
    check({tag, " R3/R4 result"}, out_result, exp_res);
  endtask

  task automatic step(input logic v, input logic [17:0] d, input int n, input logic ar, input string tag);
    in_valid = v; in_data = d; in_shamt = 5'(n); in_arith = ar;
    @(posedge clk);
    exp_valid = v;
    if (v) begin
      exp_res = ref_shift(d, n, ar);
      exp_err = (n > 16);
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    logic [17:0] corner [5];
    corner[0] = 18'h00000; corner[1] = 18'h3FFFF; corner[2] = 18'h20000;
    corner[3] = 18'h1FFFF; corner[4] = 18'h00001;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    for (int ar = 0; ar < 2; ar++) begin
      for (int n = 0; n < 32; n++) begin
        for (int k = 0; k < 9; k++) begin
          logic [17:0] d;
          d = (k < 5) ? corner[k] : 18'($urandom);
          // R3 R4 R5 R6 R8: every amount and mode, back to back
          step(1'b1, d, n, ar[0], (n > 16) ? "R6 range" : (ar != 0 ? "R4 arith" : "R3 logic"));
        end
        // R7: idle strobe with an illegal amount and junk data must hold
        step(1'b0, 18'($urandom), 31, ~ar[0], "R7 hold");
      end
    end

    // sign fill against error: negative data then illegal then legal
    step(1'b1, 18'h20000, 16, 1'b1, "R4 most negative max shift");
    step(1'b1, 18'h20000, 17, 1'b1, "R6 most negative illegal");
    step(1'b1, 18'h3FFFF, 0, 1'b1, "R5 shift zero");
    step(1'b1, 18'h3FFFF, 16, 1'b0, "R3 logical all ones");
    step(1'b0, 18'h00000, 0, 1'b0, "R7 idle");
    step(1'b0, 18'h12345, 3, 1'b1, "R7 idle again");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule